// File: doc/BRIEF.md
# Line Loss-Of-Signal Detector

The detector watches a recovered receive bit stream, one bit per recovered-clock interval. Each interval is marked by a one-cycle `bit_en` strobe. The block raises a loss-of-signal flag when the line goes quiet and drops the flag once the line carries usable traffic again. The rule that raises the flag is a count of consecutive zero intervals. The rule that drops it is different: a ones-density test over a sliding window, or a run of intervals that carry live, well-formed signal. A mode bit picks one of two rule sets. The short mode reacts within tens of intervals. The long mode waits thousands of intervals before declaring a loss.

An external comparator supplies `amp_ok`, a qualifier that is high when the line amplitude is above the clearing threshold. While the flag is raised, the block also asks a downstream clock mux to substitute the master clock. It hands the clock back only on a master-clock edge that comes after the flag has dropped. The received data is passed through untouched at all times.

Top module: `los_monitor`

## Requirements
- R1: `data_out` always equals `bit_in`, whether or not loss of signal is flagged.
- R2: With `mode_long`=0, `los` rises at the clock edge that accepts the 32nd consecutive zero interval. A mark resets the run, so 31 zeros followed by a mark leave `los` low. Cycles with `bit_en`=0 neither extend nor break a run.
- R3: With `mode_long`=1, `los` rises at the edge that accepts the 2048th consecutive zero interval, and not before.
- R4: In short mode, `los` falls at the first accepted interval at which three things hold. The last 32 accepted intervals, the current one included, hold at least 4 marks. Those 32 intervals contain no run of 16 or more zeros. `amp_ok` is high.
- R5: In short mode, an interval with `amp_ok` low never clears `los`, even when the density and run conditions are met.
- R6: In long mode, `los` falls at the 33rd consecutive accepted interval that has `amp_ok` high and a current zero run of at most 15. A single interval that fails this restarts the count.
- R7: `use_mclk` rises together with `los`. It stays high while `los` is high. It falls on the first clock at which `mclk_edge` is 1 and `los` is already low.
- R8: A change of `mode_long` restarts the zero-run, window and activity state on that clock, and `los` keeps its value. Only zeros accepted after the change count toward the next assertion.
- R9: The zero-run count saturates at 2048. A long outage never wraps it, and `los` stays high through an outage of any length.
- R10: A synchronous high `rst` forces `los` and `use_mclk` low and clears all run and window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_long | input | 1 | Rule select: 0 short window, 1 long window |
| bit_en | input | 1 | One-cycle strobe marking a received interval |
| bit_in | input | 1 | Received interval value, 1 = mark |
| amp_ok | input | 1 | Line amplitude above clearing threshold |
| mclk_edge | input | 1 | Strobe marking a master-clock edge |
| los | output | 1 | Loss-of-signal flag |
| use_mclk | output | 1 | Clock mux select, 1 = master clock |
| data_out | output | 1 | Received data passed through |

## Verification
The in-line assertions check several things on every cycle. The zero-run count never passes its saturation value. The running mark count always equals the population of the window register. Every rise of `los` follows an accepted zero, and every fall follows an accepted interval with `amp_ok` high. `use_mclk` covers `los` and falls only on a master-clock edge after `los` is low. The exact interval at which the flag rises or falls can only be shown by the bench's scenarios: the 32- and 2048-zero thresholds, the 16-zero gap rule that holds off a short-mode clear, the restart of the long-mode activity count, and the restart on a mode change.

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int WIN       = 32,
  parameter int SHORT_SET = 32,
  parameter int LONG_SET  = 2048,
  parameter int MIN_MARKS = 4,
  parameter int MAX_GAP   = 15,
  parameter int LONG_CLR  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_long,
  input  logic bit_en,
  input  logic bit_in,
  input  logic amp_ok,
  input  logic mclk_edge,
  output logic los,
  output logic use_mclk,
  output logic data_out
);
  localparam int ZW = $clog2(LONG_SET + 1);
  localparam int CW = $clog2(WIN + 1);
  localparam int AW = $clog2(LONG_CLR + 2);

  logic           mode_q, restart, los_d;
  logic [ZW-1:0]  zrun, zrun_nx;
  logic [WIN-1:0] win;
  logic [CW-1:0]  ones, ones_nx, gap_age, gap_nx;
  logic [AW-1:0]  act, act_nx;
  logic           set_hit, short_ok, long_ok;

  assign data_out = bit_in;
  assign restart  = mode_long != mode_q;

  assign zrun_nx = bit_in ? '0 : (zrun == ZW'(LONG_SET) ? zrun : zrun + 1'b1);
  assign ones_nx = ones + CW'(bit_in) - CW'(win[WIN-1]);
  assign gap_nx  = (zrun_nx > ZW'(MAX_GAP)) ? '0
                 : (gap_age == CW'(WIN) ? gap_age : gap_age + 1'b1);
  assign act_nx  = (amp_ok && zrun_nx <= ZW'(MAX_GAP))
                 ? (act == AW'(LONG_CLR + 1) ? act : act + 1'b1) : '0;

  assign set_hit  = zrun_nx >= (mode_long ? ZW'(LONG_SET) : ZW'(SHORT_SET));
  assign short_ok = amp_ok && ones_nx >= CW'(MIN_MARKS) && gap_nx >= CW'(WIN - MAX_GAP);
  assign long_ok  = act_nx > AW'(LONG_CLR);

  always_comb begin
    los_d = los;
    if (bit_en && !restart) begin
      if (!los && set_hit) los_d = 1'b1;
      else if (los && (mode_long ? long_ok : short_ok)) los_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= mode_long;
      zrun    <= '0;
      win     <= '0;
      ones    <= '0;
      gap_age <= '0;
      act     <= '0;
    end else if (restart) begin
      mode_q  <= mode_long;
      zrun    <= '0;
      win     <= '0;
      ones    <= '0;
      gap_age <= '0;
      act     <= '0;
    end else if (bit_en) begin
      zrun    <= zrun_nx;
      win     <= {win[WIN-2:0], bit_in};
      ones    <= ones_nx;
      gap_age <= gap_nx;
      act     <= act_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      los      <= 1'b0;
      use_mclk <= 1'b0;
    end else begin
      los <= los_d;
      if (los_d) use_mclk <= 1'b1;
      else if (!los && mclk_edge) use_mclk <= 1'b0;
    end
  end

  // R9
  zrun_sat_chk: assert property (@(posedge clk) disable iff (rst)
    zrun <= ZW'(LONG_SET));

  // R4
  ones_count_chk: assert property (@(posedge clk) disable iff (rst)
    ones == CW'($countones(win)));

  // R2
  los_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> $past(bit_en && !bit_in));

  // R5
  los_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los) |-> $past(bit_en && amp_ok));

  // R7
  mclk_cover_chk: assert property (@(posedge clk) disable iff (rst)
    los |-> use_mclk);

  // R7
  mclk_return_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(use_mclk) |-> $past(mclk_edge && !los));
endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_long = 1'b0, bit_en = 1'b0, bit_in = 1'b0, amp_ok = 1'b0, mclk_edge = 1'b0;
  logic los, use_mclk, data_out;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  los_monitor u_los_monitor (
    .clk(clk), .rst(rst), .mode_long(mode_long), .bit_en(bit_en), .bit_in(bit_in),
    .amp_ok(amp_ok), .mclk_edge(mclk_edge), .los(los), .use_mclk(use_mclk),
    .data_out(data_out)
  );

  // {mode, expected los, zero count}
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 1'b0, 12'd31}, {1'b0, 1'b1, 12'd32}, {1'b0, 1'b1, 12'd40},
    {1'b1, 1'b0, 12'd100}, {1'b1, 1'b0, 12'd2047}, {1'b1, 1'b1, 12'd2048}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(logic en, logic b, logic a, logic m);
    @(negedge clk);
    bit_en = en; bit_in = b; amp_ok = a; mclk_edge = m;
    @(posedge clk);
    #1;
    bit_en = 1'b0; mclk_edge = 1'b0;
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst = 1'b1; mode_long = m; bit_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R10 reset state
    check("R10 los", los, 0);
    check("R10 use_mclk", use_mclk, 0);

    for (int v = 0; v < 6; v++) begin
      do_reset(VEC[v][13]);
      zeros(int'(VEC[v][11:0]));
      check(VEC[v][13] ? "R3 vector los" : "R2 vector los", los, VEC[v][12]);
      check("R7 vector use_mclk", use_mclk, VEC[v][12]);
    end

    // R2: idle cycles do not break or extend a run; a mark restarts it
    do_reset(1'b0);
    zeros(31);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2 mark restarts run", los, 0);
    zeros(16);
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
    zeros(15);
    check("R2 idle ignored, 31 zeros", los, 0);
    zeros(1);
    check("R2 32nd zero sets", los, 1);

    // R1 passthrough during LOS
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R1 data_out mark", data_out, 1);
    @(negedge clk); bit_in = 1'b0; #1;
    check("R1 data_out space", data_out, 0);

    // R10 reset mid-run
    do_reset(1'b0);
    check("R10 los cleared", los, 0);
    zeros(20);
    do_reset(1'b0);
    zeros(31);
    check("R10 run cleared", los, 0);

    // R5 then R4: density clear held off by amp_ok
    do_reset(1'b0);
    zeros(32);
    for (int i = 1; i <= 25; i++) tick(1'b1, (i % 8) == 1, 1'b0, 1'b0);
    check("R5 amp low holds los", los, 1);
    tick(1'b1, 1'b0, 1'b1, 1'b0);
    check("R4 clear once amp high", los, 0);

    // R4 gap rule: 4 marks early but 16-zero run still in window
    do_reset(1'b0);
    zeros(32);
    for (int i = 1; i <= 16; i++) tick(1'b1, (i % 4) == 1, 1'b1, 1'b0);
    check("R4 long gap in window holds los", los, 1);
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    check("R4 gap leaves window, clears", los, 0);
    check("R7 use_mclk held after clear", use_mclk, 1);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 use_mclk drops on mclk edge", use_mclk, 0);

    // R6 long-mode activity clear with one restart
    do_reset(1'b1);
    zeros(2048);
    for (int j = 1; j <= 20; j++) tick(1'b1, j[0], 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    for (int j = 1; j <= 32; j++) tick(1'b1, j[0], 1'b1, 1'b0);
    check("R6 32 active intervals hold los", los, 1);
    tick(1'b1, 1'b0, 1'b1, 1'b0);
    check("R6 33rd active interval clears", los, 0);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 long-mode use_mclk drop", use_mclk, 0);

    // R9 very long outage with amplitude present
    do_reset(1'b1);
    for (int i = 0; i < 5000; i++) tick(1'b1, 1'b0, 1'b1, 1'b0);
    check("R9 los held through saturation", los, 1);

    // R8 mode change restarts counters, keeps los
    do_reset(1'b0);
    zeros(20);
    @(negedge clk); mode_long = 1'b1;
    @(negedge clk); mode_long = 1'b0;
    @(negedge clk);
    zeros(31);
    check("R8 run restarted", los, 0);
    zeros(1);
    check("R8 sets after 32 fresh zeros", los, 1);
    @(negedge clk); mode_long = 1'b1;
    @(negedge clk); #1;
    check("R8 los kept over mode change", los, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule